// File: doc/BRIEF.md
# Iterative Wide Counter Incrementer

This block adds one to a wide counter block, modulo two to the power of the counter width, using a single narrow adder. The adder is shared across the slices of the counter over successive cycles, and the carry is held in a flip-flop between them. With the default parameters the counter is 128 bits wide and is split into eight 16-bit slices. A full increment therefore takes eight cycles. This leaves ample margin inside the shortest block period of a cipher that needs a fresh counter value every twelve cycles or more.

A one-cycle start pulse loads the counter value in parallel from `ctr_i`. The controller then works from the least significant slice upward. In each working cycle it presents the new value of one slice on `slice_o` and raises the matching bit of `slice_we_o`, so that an external initialisation-vector register can be rewritten one slice per cycle. The full result is also available on `ctr_o`. A one-cycle `done_o` pulse marks the end of the update. A start request that arrives while the block is busy is ignored.

The controller has three states. IDLE waits for a start request. WALK performs one slice per cycle. FINISH raises the done pulse. The transitions are: IDLE to WALK on an accepted start; WALK to WALK while slices remain; WALK to FINISH after the last slice; FINISH to IDLE unconditionally.

Top module: `ctr_iter_inc`

## Requirements
- R1: After reset `busy_o`, `done_o` and every bit of `slice_we_o` are 0.
- R2: After an accepted start with value V on `ctr_i`, `ctr_o` equals (V + 1) mod 2^128 when `done_o` is high.
- R3: An all-ones input wraps to an all-zero result.
- R4: `done_o` is high exactly in the ninth cycle after the clock edge that accepts the start, whatever the carry pattern of V.
- R5: In the k-th cycle after acceptance (k = 0 to 7), `slice_we_o` equals 1 << k, and `slice_o` carries bits [16k+15:16k] of the result. Slices are processed from least to most significant.
- R6: A start request while `busy_o` is high has no effect on the result or on its timing.
- R7: `done_o` lasts one cycle. `busy_o` is high from the cycle after acceptance through the done cycle, and low afterwards.
- R8: While idle, `ctr_o` holds the last result unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start request, sampled when idle |
| ctr_i | input | 128 | Counter value loaded on start |
| ctr_o | output | 128 | Working and final counter value |
| slice_o | output | 16 | New value of the slice being written |
| slice_we_o | output | 8 | One-hot write enable for the slice on `slice_o` |
| busy_o | output | 1 | Increment in progress |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The bench sweeps carry chains that die after every slice position, from zero through all ones. A design that dropped the carry between cycles, or stopped walking early, would produce wrong upper slices. A design that exited early when the carry died would also raise `done_o` in a different cycle. The bench mirrors an external register from `slice_we_o` and `slice_o`, so writes in the wrong order or to the wrong slice show up as a mismatched mirror. It also pulses start with a different value in the middle of a run; a controller that reloaded on that pulse would return the wrong result or finish late.

// File: rtl/ctr_inc_pkg.sv
package ctr_inc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_WALK   = 2'd1,
        ST_FINISH = 2'd2
    } inc_state_e;
endpackage

// File: rtl/ctr_slice_adder.sv
module ctr_slice_adder #(
    parameter int SLICE_W = 16
) (
    input  logic [SLICE_W-1:0] a_i,
    input  logic               cin_i,
    output logic [SLICE_W-1:0] sum_o,
    output logic               cout_o
);
    logic [SLICE_W:0] wide;

    always_comb begin
        wide   = {1'b0, a_i} + {{SLICE_W{1'b0}}, cin_i};
        sum_o  = wide[SLICE_W-1:0];
        cout_o = wide[SLICE_W];
    end
endmodule

// File: rtl/ctr_slice_store.sv
module ctr_slice_store #(
    parameter int SLICE_W  = 16,
    parameter int N_SLICES = 8,
    localparam int WIDTH   = SLICE_W * N_SLICES
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                load_i,
    input  logic [WIDTH-1:0]    load_val_i,
    input  logic [N_SLICES-1:0] we_i,
    input  logic [SLICE_W-1:0]  wdata_i,
    output logic [WIDTH-1:0]    q_o
);
    for (genvar g = 0; g < N_SLICES; g++) begin : g_slice
        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
                q_o[g*SLICE_W +: SLICE_W] <= '0;
            end else if (load_i) begin
                q_o[g*SLICE_W +: SLICE_W] <= load_val_i[g*SLICE_W +: SLICE_W];
            end else if (we_i[g]) begin
                q_o[g*SLICE_W +: SLICE_W] <= wdata_i;
            end
        end
    end

    // R8: with no load and no write the stored value does not move
    a_r8_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!load_i && we_i == '0) |=> $stable(q_o));

    // R5: never more than one slice written per cycle
    a_r5_onehot_we: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0(we_i));
endmodule

// File: rtl/ctr_inc_fsm.sv
module ctr_inc_fsm
    import ctr_inc_pkg::*;
#(
    parameter int N_SLICES = 8,
    localparam int IDX_W   = (N_SLICES > 1) ? $clog2(N_SLICES) : 1
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                start_i,
    output logic                load_o,
    output logic                walk_o,
    output logic                busy_o,
    output logic                done_o,
    output logic [IDX_W-1:0]    idx_o
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N_SLICES - 1);

    inc_state_e state_q, state_d;
    logic [IDX_W-1:0] idx_q, idx_d;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
        end
    end

    always_comb begin
        state_d = state_q;
        idx_d   = idx_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start_i) begin
                    state_d = ST_WALK;
                    idx_d   = '0;
                end
            end
            ST_WALK: begin
                if (idx_q == LAST_IDX) begin
                    state_d = ST_FINISH;
                    idx_d   = '0;
                end else begin
                    idx_d = idx_q + 1'b1;
                end
            end
            ST_FINISH: begin
                state_d = ST_IDLE;
            end
            default: begin
                state_d = ST_IDLE;
                idx_d   = '0;
            end
        endcase
    end

    always_comb begin
        load_o = 1'b0;
        walk_o = 1'b0;
        busy_o = 1'b0;
        done_o = 1'b0;
        unique case (state_q)
            ST_IDLE:   load_o = start_i;
            ST_WALK:   begin walk_o = 1'b1; busy_o = 1'b1; end
            ST_FINISH: begin done_o = 1'b1; busy_o = 1'b1; end
            default:   ;
        endcase
        idx_o = idx_q;
    end

    // R7: done is a single-cycle pulse followed by idle
    a_r7_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> (!done_o && !busy_o));

    // R6: a start while busy never produces a load
    a_r6_no_reload: assert property (@(posedge clk_i) disable iff (!rst_ni)
        busy_o |-> !load_o);

    // R4: an accepted start always begins at slice zero
    a_r4_begin_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
        load_o |=> (walk_o && idx_o == '0));

    // R5: slice index advances by exactly one per walking cycle
    a_r5_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (walk_o && idx_o != LAST_IDX) |=> (walk_o && idx_o == $past(idx_o) + 1'b1));
endmodule

// File: rtl/ctr_iter_inc.sv
module ctr_iter_inc #(
    parameter int SLICE_W  = 16,
    parameter int N_SLICES = 8,
    localparam int CTR_W   = SLICE_W * N_SLICES,
    localparam int IDX_W   = (N_SLICES > 1) ? $clog2(N_SLICES) : 1
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                start_i,
    input  logic [CTR_W-1:0]    ctr_i,
    output logic [CTR_W-1:0]    ctr_o,
    output logic [SLICE_W-1:0]  slice_o,
    output logic [N_SLICES-1:0] slice_we_o,
    output logic                busy_o,
    output logic                done_o
);
    logic               load, walk, carry_q, carry_out;
    logic [IDX_W-1:0]   idx;
    logic [SLICE_W-1:0] cur_slice, new_slice;
    logic [CTR_W-1:0]   store_q;

    ctr_inc_fsm #(.N_SLICES(N_SLICES)) u_fsm (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .start_i (start_i),
        .load_o  (load),
        .walk_o  (walk),
        .busy_o  (busy_o),
        .done_o  (done_o),
        .idx_o   (idx)
    );

    assign cur_slice = store_q[idx*SLICE_W +: SLICE_W];

    ctr_slice_adder #(.SLICE_W(SLICE_W)) u_add (
        .a_i    (cur_slice),
        .cin_i  (carry_q),
        .sum_o  (new_slice),
        .cout_o (carry_out)
    );

    // carry is seeded with one on load, then passed slice to slice
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)      carry_q <= 1'b0;
        else if (load)    carry_q <= 1'b1;
        else if (walk)    carry_q <= carry_out;
    end

    always_comb begin
        slice_we_o = '0;
        if (walk) slice_we_o[idx] = 1'b1;
    end

    ctr_slice_store #(.SLICE_W(SLICE_W), .N_SLICES(N_SLICES)) u_store (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .load_i     (load),
        .load_val_i (ctr_i),
        .we_i       (slice_we_o),
        .wdata_i    (new_slice),
        .q_o        (store_q)
    );

    assign slice_o = new_slice;
    assign ctr_o   = store_q;

    // R2: once the carry has died, remaining slices pass through unchanged
    a_r2_dead_carry: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (walk && !carry_q) |-> (slice_o == cur_slice));

    // R3: a live carry out of a slice means that slice wrapped to zero
    a_r3_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (walk && carry_out) |-> (slice_o == '0));
endmodule

// File: tb/ctr_iter_inc_tb.sv
module ctr_iter_inc_tb;
    localparam int SW = 16;
    localparam int NS = 8;
    localparam int CW = SW * NS;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [CW-1:0] ctr_in = '0;
    logic [CW-1:0] ctr_out;
    logic [SW-1:0] slice;
    logic [NS-1:0] we;
    logic          busy, done;

    int checks = 0;
    int errors = 0;
    logic [CW-1:0] mirror;

    always #2.5 clk = ~clk;

    ctr_iter_inc u_dut (
        .clk_i(clk), .rst_ni(rst_n), .start_i(start), .ctr_i(ctr_in),
        .ctr_o(ctr_out), .slice_o(slice), .slice_we_o(we),
        .busy_o(busy), .done_o(done)
    );

    task automatic chk(input bit ok, input string req, input logic [CW-1:0] act,
                       input logic [CW-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic run_inc(input logic [CW-1:0] v, input bit poke);
        logic [CW-1:0] exp;
        exp = v + 128'd1;
        mirror = v;
        @(negedge clk);
        start = 1'b1; ctr_in = v;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0; ctr_in = ~v;
        for (int k = 0; k < NS; k++) begin
            chk(we == NS'(1) << k, "R5 write enable", CW'(we), CW'(NS'(1) << k));
            chk(slice == exp[k*SW +: SW], "R5 slice data", CW'(slice), CW'(exp[k*SW +: SW]));
            chk(busy && !done, "R4 busy no done", CW'({busy, done}), CW'(2'b10));
            if (we[k]) mirror[k*SW +: SW] = slice;
            if (poke && k == 2) start = 1'b1;
            @(posedge clk);
            @(negedge clk);
            start = 1'b0;
        end
        chk(done === 1'b1, "R4 done timing", CW'(done), CW'(1));
        chk(ctr_out == exp, poke ? "R6 start ignored" : "R2 result", ctr_out, exp);
        chk(mirror == exp, "R5 mirror", mirror, exp);
        chk(we == '0, "R5 no write in done", CW'(we), '0);
        @(posedge clk);
        @(negedge clk);
        chk(!done && !busy, "R7 done one cycle", CW'({busy, done}), '0);
        @(posedge clk);
        @(negedge clk);
        chk(ctr_out == exp, "R8 hold", ctr_out, exp);
    endtask

    initial begin
        #20000;
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [CW-1:0] hi;
        #1;
        chk(!busy && !done && we == '0, "R1 reset", CW'({busy, done, we}), '0);
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        chk(!busy && !done && we == '0, "R1 after reset", CW'({busy, done, we}), '0);
        run_inc('0, 1'b0);
        run_inc({CW{1'b1}}, 1'b0);
        chk(ctr_out == '0, "R3 wrap", ctr_out, '0);
        hi = 128'hA5C3_0F96_1234_5678_9ABC_DEF0_0BAD_F00D;
        for (int k = 1; k < NS; k++) begin
            run_inc((hi << (k*SW)) | ((CW'(1) << (k*SW)) - 1), 1'b0);
        end
        run_inc(128'h0000_FFFF_0000_FFFF_0000_FFFF_0000_FFFE, 1'b0);
        run_inc(128'h7FFF_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF, 1'b1);
        run_inc(128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_FFFF, 1'b1);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule